// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the CPU-side controller for taking and leaving interrupts. It keeps a sticky pending flag for every hardware source and qualifies each flag against that source's enable bit and the global mask bit of the condition-code register, which it owns. A software-interrupt request from the instruction decoder bypasses the mask. A return request starts the exit sequence. The block acts on any of these requests only in a cycle where the decoder signals that an instruction has just completed.

On entry, the block writes a five-byte frame to the byte-wide stack in memory. It then sets the mask bit and reads the big-endian 16-bit vector of the winning source. Finally it reads three opcode bytes from the vectored address into the instruction queue. On return, it pops the frame in the reverse order. The popped condition-code byte is the only thing that brings the mask back. The index-high register is not part of the frame.

The register file sees plain load strobes with values. The decoder sees a busy level and a one-cycle done pulse. The memory port is synchronous, and read data is returned one cycle after the read strobe.

Top module: `irq_seq`

## Requirements
- R1: A source's pending flag sets on its event pulse and clears only on its clear input; the event wins when both are high. The sequencer never clears a flag, so a flag left set takes entry again after a return.
- R2: The mask bit is bit 3 of `ccr`. Reset loads `ccr` with 8'h08. A hardware source qualifies only when it is pending, its enable is 1 and the mask bit is 0.
- R3: A request is acted on only in a cycle where `insn_done` is high and the block is idle. `busy` rises on the next clock edge.
- R4: Entry writes exactly five bytes: PC low, PC high, X, A, CCR. They go to SP, SP-1, SP-2, SP-3 and SP-4, and `sp_out` reports SP-5. No index-high byte is written.
- R5: The stacked CCR byte holds the mask value from before entry. After entry, bit 3 of `ccr` is 1.
- R6: Among qualified sources, the lowest index wins. The high byte of source n's vector is at 16'hFFFE-2n and the low byte at the next address. At entry done, `pc_out` carries this vector.
- R7: Three queue bytes are read from vector, vector+1 and vector+2, and are delivered with `q_idx` 0, 1 and 2 in that order.
- R8: When `swi_req` is high at a boundary, entry starts whatever the mask and the pending sources, and uses the slot at 16'hFFFE-2*NSRC. `rti_req` has priority over `swi_req`, and `swi_req` has priority over hardware sources.
- R9: A return reads SP+1 to SP+5 as CCR, A, X, PC high and PC low. It restores `ccr`, pulses `ld_a`, `ld_x`, `ld_pc` and `ld_sp` with the popped values, and reports SP+5.
- R10: `done` is a single-cycle pulse with `busy` high. For entry, it appears in the 16th cycle counted from the cycle that drives the boundary; for a return, it appears in the 11th.
- R11: While idle, a `ccr_we` write takes effect on the next edge. If the mask is cleared inside a service routine, a qualified request enters again, nesting a second frame below the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_event | input | NSRC | Event pulse per hardware source |
| src_clr | input | NSRC | Software clear per pending flag |
| src_en | input | NSRC | Local enable per source |
| insn_done | input | 1 | Instruction boundary strobe |
| swi_req | input | 1 | Software interrupt instruction completing |
| rti_req | input | 1 | Return instruction completing |
| ccr_we | input | 1 | Software write of the condition-code byte |
| ccr_wdata | input | 8 | Value for that write |
| rf_pc | input | 16 | Current program counter |
| rf_a | input | 8 | Current accumulator |
| rf_x | input | 8 | Current index-low register |
| rf_sp | input | 16 | Current stack pointer |
| pending | output | NSRC | Pending flags |
| ccr | output | 8 | Condition-code byte |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| q_wr | output | 1 | Instruction queue byte valid |
| q_idx | output | 2 | Queue slot of that byte |
| q_data | output | 8 | Queue byte |
| ld_pc | output | 1 | Load program counter |
| pc_out | output | 16 | Program counter value |
| ld_a | output | 1 | Load accumulator |
| a_out | output | 8 | Accumulator value |
| ld_x | output | 1 | Load index-low register |
| x_out | output | 8 | Index-low value |
| ld_sp | output | 1 | Load stack pointer |
| sp_out | output | 16 | Stack pointer value |

## Verification
Each sequence starts on the clock edge that samples the boundary strobe. Entry then spends five cycles on stack writes and five read pairs of two cycles each before `done`. A return spends five read pairs before `done`. The bench counts falling edges from the cycle that drives the strobe, collects queue bytes and write strobes along the way, and requires `done` on exactly the 16th or 11th of those edges. Stack contents are read from the bench memory model only after `done`, and flag or mask effects are sampled at least one edge after the input that caused them.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int MASK_BIT = 3;
  localparam logic [7:0] CCR_RESET = 8'(1 << MASK_BIT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_RDI, ST_RDW, ST_POPI, ST_POPW, ST_DONE
  } seq_st_t;

  // Address of the high vector byte for a slot index.
  function automatic logic [15:0] vec_slot(input logic [15:0] top, input int unsigned idx);
    return top - 16'(2 * idx);
  endfunction

  // Byte k of the stacked frame, in push order.
  function automatic logic [7:0] frame_byte(input logic [2:0] k, input logic [15:0] pc,
                                             input logic [7:0] x, input logic [7:0] a,
                                             input logic [7:0] c);
    case (k)
      3'd0:    return pc[7:0];
      3'd1:    return pc[15:8];
      3'd2:    return x;
      3'd3:    return a;
      default: return c;
    endcase
  endfunction

  // Read k: two vector bytes, then three queue bytes.
  function automatic logic [15:0] read_addr(input logic [2:0] k, input logic [15:0] slot,
                                             input logic [15:0] vec);
    return (k < 3'd2) ? slot + 16'(k) : vec + 16'(k - 3'd2);
  endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] flags
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[gi] <= 1'b0;
      else if (ev[gi])    flags[gi] <= 1'b1;
      else if (clr[gi])   flags[gi] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NSRC = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] qual,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          NSRC    = 4,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  localparam int         IW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_event,
  input  logic [NSRC-1:0] src_clr,
  input  logic [NSRC-1:0] src_en,
  input  logic            insn_done,
  input  logic            swi_req,
  input  logic            rti_req,
  input  logic            ccr_we,
  input  logic [7:0]      ccr_wdata,
  input  logic [15:0]     rf_pc,
  input  logic [7:0]      rf_a,
  input  logic [7:0]      rf_x,
  input  logic [15:0]     rf_sp,
  output logic [NSRC-1:0] pending,
  output logic [7:0]      ccr,
  output logic            busy,
  output logic            done,
  output logic [15:0]     mem_addr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            q_wr,
  output logic [1:0]      q_idx,
  output logic [7:0]      q_data,
  output logic            ld_pc,
  output logic [15:0]     pc_out,
  output logic            ld_a,
  output logic [7:0]      a_out,
  output logic            ld_x,
  output logic [7:0]      x_out,
  output logic            ld_sp,
  output logic [15:0]     sp_out
);
  seq_st_t     st;
  logic [2:0]  cnt;
  logic [15:0] sp_w, slot, vec;
  logic        is_ret;
  logic [15:0] fr_pc;
  logic [7:0]  fr_a, fr_x, fr_ccr;
  logic [7:0]  p_a, p_x, p_pch, p_pcl;

  // Named events for the checker.
  logic [NSRC-1:0] qual;
  logic            irq_any;
  logic [IW-1:0]   irq_idx;
  logic            boundary, start_ret, start_swi, start_hw, start_entry;
  logic            mask_set, ccr_restore, last_step;

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .ev(src_event), .clr(src_clr), .flags(pending)
  );

  assign qual = pending & src_en & {NSRC{~ccr[MASK_BIT]}};

  irq_arb #(.NSRC(NSRC)) u_arb (.qual(qual), .any(irq_any), .idx(irq_idx));

  assign boundary    = (st == ST_IDLE) && insn_done;
  assign start_ret   = boundary && rti_req;
  assign start_swi   = boundary && !rti_req && swi_req;
  assign start_hw    = boundary && !rti_req && !swi_req && irq_any;
  assign start_entry = start_swi || start_hw;
  assign last_step   = (cnt == 3'd4);
  assign mask_set    = (st == ST_PUSH) && last_step;
  assign ccr_restore = (st == ST_POPW) && (cnt == 3'd0);

  // Condition-code byte: software writes when idle, entry sets the mask, return restores.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ccr <= CCR_RESET;
    else if (ccr_restore)              ccr <= mem_rdata;
    else if (mask_set)                 ccr[MASK_BIT] <= 1'b1;
    else if (st == ST_IDLE && ccr_we)  ccr <= ccr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sp_w   <= '0;
      slot   <= '0;
      vec    <= '0;
      is_ret <= 1'b0;
      fr_pc  <= '0;
      fr_a   <= '0;
      fr_x   <= '0;
      fr_ccr <= '0;
      p_a    <= '0;
      p_x    <= '0;
      p_pch  <= '0;
      p_pcl  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (start_ret) begin
            st     <= ST_POPI;
            sp_w   <= rf_sp;
            is_ret <= 1'b1;
          end else if (start_entry) begin
            st     <= ST_PUSH;
            sp_w   <= rf_sp;
            is_ret <= 1'b0;
            fr_pc  <= rf_pc;
            fr_a   <= rf_a;
            fr_x   <= rf_x;
            fr_ccr <= ccr;
            slot   <= start_swi ? vec_slot(VEC_TOP, NSRC) : vec_slot(VEC_TOP, int'(irq_idx));
          end
        end
        ST_PUSH: begin
          sp_w <= sp_w - 16'd1;
          cnt  <= last_step ? 3'd0 : cnt + 3'd1;
          if (last_step) st <= ST_RDI;
        end
        ST_RDI: st <= ST_RDW;
        ST_RDW: begin
          if (cnt == 3'd0) vec[15:8] <= mem_rdata;
          if (cnt == 3'd1) vec[7:0]  <= mem_rdata;
          cnt <= cnt + 3'd1;
          st  <= last_step ? ST_DONE : ST_RDI;
        end
        ST_POPI: begin
          sp_w <= sp_w + 16'd1;
          st   <= ST_POPW;
        end
        ST_POPW: begin
          case (cnt)
            3'd1:    p_a   <= mem_rdata;
            3'd2:    p_x   <= mem_rdata;
            3'd3:    p_pch <= mem_rdata;
            3'd4:    p_pcl <= mem_rdata;
            default: ;
          endcase
          cnt <= cnt + 3'd1;
          st  <= last_step ? ST_DONE : ST_POPI;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = (st == ST_PUSH);
    mem_re    = (st == ST_RDI) || (st == ST_POPI);
    mem_wdata = frame_byte(cnt, fr_pc, fr_x, fr_a, fr_ccr);
    case (st)
      ST_PUSH: mem_addr = sp_w;
      ST_RDI:  mem_addr = read_addr(cnt, slot, vec);
      ST_POPI: mem_addr = sp_w + 16'd1;
      default: mem_addr = '0;
    endcase
  end

  assign q_wr   = (st == ST_RDW) && (cnt >= 3'd2);
  assign q_idx  = 2'(cnt - 3'd2);
  assign q_data = mem_rdata;
  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_DONE);
  assign ld_pc  = done;
  assign pc_out = is_ret ? {p_pch, p_pcl} : vec;
  assign ld_sp  = done;
  assign sp_out = sp_w;
  assign ld_a   = done && is_ret;
  assign a_out  = p_a;
  assign ld_x   = done && is_ret;
  assign x_out  = p_x;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_clr,
  input logic [NSRC-1:0] pending,
  input logic [7:0]      ccr,
  input logic            busy,
  input logic            done,
  input logic            insn_done,
  input logic            swi_req,
  input logic            rti_req,
  input logic            mem_we,
  input logic            mem_re,
  input logic [15:0]     mem_addr,
  input logic            q_wr,
  input logic [1:0]      q_idx,
  input logic            ld_a,
  input logic            boundary
);
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pending) & ~$past(src_clr) & ~pending) == '0)); // R1

  AST_MASKED_NO_HW: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && ccr[MASK_BIT] && !swi_req && !rti_req |=> !busy); // R2

  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_done)); // R3

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - 16'd1); // R4

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R4

  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ld_a |-> ccr[MASK_BIT]); // R5

  AST_QUEUE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr |-> q_idx != 2'd3 && busy); // R7

  AST_SWI_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && swi_req |=> busy); // R8

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10
endmodule

bind irq_seq irq_seq_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_clr(src_clr), .pending(pending), .ccr(ccr),
  .busy(busy), .done(done), .insn_done(insn_done), .swi_req(swi_req),
  .rti_req(rti_req), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .q_wr(q_wr), .q_idx(q_idx), .ld_a(ld_a), .boundary(boundary)
);

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_event = '0, src_clr = '0, src_en = '0;
  logic insn_done = 1'b0, swi_req = 1'b0, rti_req = 1'b0, ccr_we = 1'b0;
  logic [7:0]  ccr_wdata = '0, rf_a = '0, rf_x = '0;
  logic [15:0] rf_pc = '0, rf_sp = 16'h00C0;
  logic [NSRC-1:0] pending;
  logic [7:0]  ccr, mem_wdata, mem_rdata, q_data, a_out, x_out;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic busy, done, mem_re, mem_we, q_wr, ld_pc, ld_a, ld_x, ld_sp;
  logic [1:0] q_idx;

  always #4 clk = ~clk;

  irq_seq #(.NSRC(NSRC)) i_irq_seq (.*);

  // Byte memory model, indexed by the low address byte.
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  function automatic logic [7:0] fill(input int j);
    return 8'(j * 7 + 3);
  endfunction
  function automatic logic [15:0] exp_vec(input int n);
    return {8'(8'h40 + n), 8'(8'h20 + 16 * n)};
  endfunction
  function automatic int low_bit(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Results of the last sequence.
  int lat, nwr;
  logic [7:0]  qb [3];
  logic [15:0] g_pc, g_sp;
  logic [7:0]  g_a, g_x, g_ccr;
  logic g_lda;

  task automatic run_seq(input bit rti, input bit swi);
    @(negedge clk);
    insn_done = 1'b1; rti_req = rti; swi_req = swi;
    lat = -1; nwr = 0;
    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      insn_done = 1'b0; rti_req = 1'b0; swi_req = 1'b0;
      if (q_wr) qb[q_idx] = q_data;
      if (mem_we) nwr++;
      if (done) begin
        lat = c; g_pc = pc_out; g_sp = sp_out; g_a = a_out; g_x = x_out;
        g_ccr = ccr; g_lda = ld_a;
        break;
      end
    end
  endtask

  task automatic write_ccr(input logic [7:0] v);
    @(negedge clk); ccr_we = 1'b1; ccr_wdata = v;
    @(negedge clk); ccr_we = 1'b0;
  endtask

  task automatic pulse_event(input logic [NSRC-1:0] v);
    @(negedge clk); src_event = v;
    @(negedge clk); src_event = '0;
  endtask

  task automatic clear_all;
    @(negedge clk); src_clr = '1;
    @(negedge clk); src_clr = '0;
  endtask

  // Entry for slot n with current register values; checks the frame and the queue.
  task automatic entry_check(input int n, input bit swi);
    logic [15:0] sp0;
    logic [7:0] c0;
    logic [7:0] lo;
    sp0 = rf_sp; c0 = ccr;
    run_seq(1'b0, swi);
    chk("R10 entry latency", 32'(lat), 32'd16);
    chk("R6 vector to pc", 32'(g_pc), 32'(exp_vec(n)));
    chk("R4 sp after entry", 32'(g_sp), 32'(sp0 - 16'd5));
    chk("R4 five bytes written, no H", 32'(nwr), 32'd5);
    chk("R4 stacked pcl", 32'(mem[sp0[7:0]]), 32'(rf_pc[7:0]));
    chk("R4 stacked pch", 32'(mem[8'(sp0 - 16'd1)]), 32'(rf_pc[15:8]));
    chk("R4 stacked x", 32'(mem[8'(sp0 - 16'd2)]), 32'(rf_x));
    chk("R4 stacked a", 32'(mem[8'(sp0 - 16'd3)]), 32'(rf_a));
    chk("R5 stacked ccr keeps old mask", 32'(mem[8'(sp0 - 16'd4)]), 32'(c0));
    chk("R5 mask set after entry", 32'(g_ccr[3]), 32'd1);
    lo = 8'(8'h20 + 16 * n);
    for (int k = 0; k < 3; k++)
      chk("R7 queue byte", 32'(qb[k]), 32'(fill(int'(lo) + k)));
    rf_sp = g_sp;
  endtask

  task automatic return_check(input logic [15:0] pc, input logic [7:0] a, input logic [7:0] x,
                              input logic [7:0] c);
    logic [15:0] sp0;
    sp0 = rf_sp;
    run_seq(1'b1, 1'b0);
    chk("R10 return latency", 32'(lat), 32'd11);
    chk("R9 popped pc", 32'(g_pc), 32'(pc));
    chk("R9 popped a", 32'(g_a), 32'(a));
    chk("R9 popped x", 32'(g_x), 32'(x));
    chk("R9 ld_a on return", 32'(g_lda), 32'd1);
    chk("R9 ccr restored", 32'(g_ccr), 32'(c));
    chk("R9 sp after return", 32'(g_sp), 32'(sp0 + 16'd5));
    rf_sp = g_sp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 256; j++) mem[j] = fill(j);
    for (int n = 0; n <= NSRC; n++) begin
      mem[8'hFE - 2 * n] = exp_vec(n)[15:8];
      mem[8'hFF - 2 * n] = exp_vec(n)[7:0];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset ccr", 32'(ccr), 32'h08);
    chk("R3 idle after reset", 32'(busy), 32'd0);
    chk("R1 no flags after reset", 32'(pending), 32'd0);

    // Masked: pending and enabled but mask set.
    src_en = '1;
    pulse_event(4'hF);
    chk("R1 flags set by events", 32'(pending), 32'hF);
    run_seq(1'b0, 1'b0);
    chk("R2 masked request ignored", 32'(lat), 32'hFFFFFFFF);
    chk("R2 no write while masked", 32'(nwr), 32'd0);

    // SWI ignores the mask and beats pending sources.
    rf_pc = 16'h2345; rf_a = 8'h11; rf_x = 8'h22;
    entry_check(NSRC, 1'b1);
    return_check(16'h2345, 8'h11, 8'h22, 8'h08);
    chk("R2 mask restored only by pop", 32'(ccr[3]), 32'd1);

    // Qualified but no boundary strobe: stays idle.
    write_ccr(8'h00);
    chk("R11 ccr write lands", 32'(ccr), 32'h00);
    repeat (8) @(negedge clk);
    chk("R3 no entry without boundary", 32'(busy), 32'd0);

    // SWI also beats a qualified hardware source with mask clear.
    entry_check(NSRC, 1'b1);
    return_check(16'h2345, 8'h11, 8'h22, 8'h00);
    clear_all();
    chk("R1 clear input drops flags", 32'(pending), 32'h0);

    // Sweep pending patterns, all enabled.
    for (int p = 1; p < 16; p++) begin
      logic [7:0] cv;
      cv = {4'(p), 4'b0000};
      write_ccr(cv);
      rf_pc = 16'(16'h1000 + p * 16'h0111); rf_a = 8'(p * 3); rf_x = ~8'(p);
      pulse_event(4'(p));
      entry_check(low_bit(4'(p)), 1'b0);
      return_check(rf_pc, rf_a, rf_x, cv);
      chk("R1 flags not cleared by sequencer", 32'(pending), 32'(p));
      clear_all();
    end

    // Sweep enable patterns with every source pending.
    for (int e = 0; e < 16; e++) begin
      src_en = 4'(e);
      write_ccr(8'h00);
      pulse_event(4'hF);
      rf_pc = 16'(16'h3000 + e); rf_a = 8'(e); rf_x = 8'(e + 9);
      if (e == 0) begin
        run_seq(1'b0, 1'b0);
        chk("R2 disabled sources ignored", 32'(lat), 32'hFFFFFFFF);
      end else begin
        entry_check(low_bit(4'(e)), 1'b0);
        return_check(rf_pc, rf_a, rf_x, 8'h00);
      end
      clear_all();
    end

    // Flag left set re-triggers entry after return.
    src_en = '1;
    write_ccr(8'h00);
    pulse_event(4'b0100);
    rf_pc = 16'h4444; rf_a = 8'h44; rf_x = 8'h45;
    entry_check(2, 1'b0);
    return_check(16'h4444, 8'h44, 8'h45, 8'h00);
    entry_check(2, 1'b0);
    return_check(16'h4444, 8'h44, 8'h45, 8'h00);
    clear_all();

    // Nesting: mask cleared in a service routine.
    pulse_event(4'b1000);
    rf_pc = 16'h5150; rf_a = 8'h51; rf_x = 8'h52;
    entry_check(3, 1'b0);
    @(negedge clk); src_clr = 4'b1000;
    @(negedge clk); src_clr = '0;
    pulse_event(4'b0010);
    rf_pc = 16'h6160; rf_a = 8'h61; rf_x = 8'h62;
    run_seq(1'b0, 1'b0);
    chk("R2 masked inside routine", 32'(lat), 32'hFFFFFFFF);
    write_ccr(8'h00);
    entry_check(1, 1'b0);
    chk("R11 nested frame depth", 32'(rf_sp), 32'h00B6);
    return_check(16'h6160, 8'h61, 8'h62, 8'h00);
    clear_all();
    return_check(16'h5150, 8'h51, 8'h52, 8'h00);
    chk("R11 stack back to origin", 32'(rf_sp), 32'h00C0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule